// File: doc/BRIEF.md
# Oversampled Serial Receiver Front End

This block turns an asynchronous serial line into received bytes. A sample-clock enable, pulsed at sixteen times the bit rate, paces a cyclic sample counter that numbers the samples of each bit period from 1 to 16. The line first passes through a two-flop synchronizer. The receiver then waits for a start condition, confirms it by voting, strobes eight data bits and one stop bit with majority voting, and reports each frame with a one-cycle valid strobe, together with noise and framing error flags.

The control is a four-state machine. IDLE goes to START on *qualify*, which is three high samples followed at once by a low one. START goes back to IDLE on *reject*, when the vote at slot 7 is mostly high. START goes to DATA on *start-wrap*, when slot 16 of the start bit completes. DATA goes to STOP on *last-advance*, when the eighth data bit completes. STOP goes to IDLE on *deliver*, when the stop bit is voted. An optional mode renumbers the counter at every line transition seen during a data bit. This absorbs a mismatch between transmitter and receiver rates.

Top module: `osrx_frontend`

## Requirements
- R1: During and directly after reset, `valid_o`, `data_o`, `noise_o` and `frame_err_o` are all 0.
- R2: While IDLE, a start is qualified only on a low sample that directly follows three consecutive high samples taken in IDLE.
- R3: The sample counter runs 1..16 cyclically. The qualifying low sample is numbered 1.
- R4: The start bit is voted on the samples numbered 3, 5 and 7. When at least two of them are high, the receiver silently returns to IDLE, and three fresh high samples are needed before the next qualification.
- R5: The noise flag of a frame is raised when exactly one of the three start-bit vote samples is high.
- R6: Each of the 8 data bits is the 2-of-3 majority of its samples numbered 8, 9 and 10. The first data bit is placed in `data_o[0]` (LSB first).
- R7: The noise flag is also raised when the three vote samples of any data bit or of the stop bit disagree. The flag reported covers the whole frame.
- R8: A stop bit voted low (0) sets `frame_err_o` = 1. The byte is still delivered.
- R9: `valid_o` is high for exactly one clock, one clock after the stop bit's sample numbered 10 is taken. `data_o`, `noise_o` and `frame_err_o` change only with it and hold between frames.
- R10: With `resync_en_i` = 1, a sample in a data bit that differs from the previous sample is numbered 1. If that bit has already been voted, the receiver moves to the next bit. With `resync_en_i` = 0, no such renumbering takes place.
- R11: A value on `rx_i` reaches the sampler two clocks later, through two flops that reset to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample enable, sixteen pulses per bit period |
| resync_en_i | input | 1 | Enables counter renumbering at data-bit transitions |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| data_o | output | 8 | Received byte, LSB received first |
| valid_o | output | 1 | One-clock strobe for a delivered frame |
| noise_o | output | 1 | Noise seen in the delivered frame |
| frame_err_o | output | 1 | Stop bit of the delivered frame voted low |

## Verification
Two renumbering causes can fall on the same sample. When resync is on and the transmitter runs at the nominal rate, the line edge that opens a data bit arrives exactly when the counter would wrap from 16 to 1 on its own. The design must then advance by one bit, not two. This is provoked with an alternating byte at sixteen samples per bit with resync enabled, and again at eighteen samples per bit, where the wrap and the edge land two samples apart. Both cases are judged by the delivered byte and by a per-clock comparison against a behavioural model of the sample stream.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/osrx_slot_ctr.sv
module osrx_slot_ctr #(
    parameter int OSR = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       load_i,
    output logic [$clog2(OSR+1)-1:0]   num_o,
    output logic [$clog2(OSR+1)-1:0]   cnt_o
);
    localparam int CW = $clog2(OSR+1);

    logic [CW-1:0] cnt_q;

    // Number carried by the sample taken on this tick
    always_comb begin
        if (load_i || cnt_q == CW'(OSR)) begin
            num_o = CW'(1);
        end else begin
            num_o = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(1);
        end else if (tick_i) begin
            cnt_q <= num_o;
        end
    end

    assign cnt_o = cnt_q;

    // R3: a renumbering request restarts the count at 1
    a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && load_i) |=> (cnt_q == CW'(1)));

    // R3: the count never leaves 1..OSR
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= CW'(1)) && (cnt_q <= CW'(OSR)));
endmodule

// File: rtl/osrx_vote3.sv
module osrx_vote3 (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic maj_o,
    output logic split_o
);
    always_comb begin
        maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
        split_o = !((a_i == b_i) && (b_i == c_i));
    end
endmodule

// File: rtl/osrx_frontend.sv
module osrx_frontend #(
    parameter int OSR         = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int VER_A       = 3,
    parameter int VER_B       = 5,
    parameter int VER_C       = 7,
    parameter int STB_A       = 8,
    parameter int STB_B       = 9,
    parameter int STB_C       = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en_i,
    input  logic                 resync_en_i,
    input  logic                 rx_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 noise_o,
    output logic                 frame_err_o
);
    import osrx_pkg::*;

    localparam int CW = $clog2(OSR+1);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS-1);

    rx_state_e            st_q, st_n;
    logic                 smp;
    logic                 prev_q;
    logic [2:0]           hist_q;
    logic [1:0]           vs_q;
    logic [DATA_BITS-1:0] sr_q;
    logic [BW-1:0]        bit_idx_q;
    logic                 done_q;
    logic                 noise_acc_q;
    logic [CW-1:0]        num, cnt;
    logic [CW-1:0]        slot_a, slot_b, slot_c;
    logic                 qual, resync_hit, load, adv;
    logic                 maj, split;

    osrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (smp)
    );

    osrx_slot_ctr #(.OSR(OSR)) ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sample_en_i),
        .load_i (load),
        .num_o  (num),
        .cnt_o  (cnt)
    );

    osrx_vote3 vote_i (
        .a_i     (vs_q[0]),
        .b_i     (vs_q[1]),
        .c_i     (smp),
        .maj_o   (maj),
        .split_o (split)
    );

    always_comb begin
        if (st_q == RX_START) begin
            slot_a = CW'(VER_A);
            slot_b = CW'(VER_B);
            slot_c = CW'(VER_C);
        end else begin
            slot_a = CW'(STB_A);
            slot_b = CW'(STB_B);
            slot_c = CW'(STB_C);
        end
        qual       = sample_en_i && (st_q == RX_IDLE) && (hist_q == 3'b111) && !smp;
        resync_hit = sample_en_i && resync_en_i && (st_q == RX_DATA) && (smp != prev_q);
        load       = qual || resync_hit;
        adv        = (st_q == RX_DATA) && (num == CW'(1)) && done_q;
    end

    // Next-state logic
    always_comb begin
        st_n = st_q;
        if (sample_en_i) begin
            unique case (st_q)
                RX_IDLE:  if (qual) st_n = RX_START;
                RX_START: begin
                    if (num == slot_c && maj)     st_n = RX_IDLE;
                    else if (num == CW'(OSR))     st_n = RX_DATA;
                end
                RX_DATA:  if (adv && bit_idx_q == LAST_BIT) st_n = RX_STOP;
                RX_STOP:  if (num == slot_c) st_n = RX_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= 1'b1;
            hist_q      <= 3'b000;
            vs_q        <= 2'b00;
            sr_q        <= '0;
            bit_idx_q   <= '0;
            done_q      <= 1'b0;
            noise_acc_q <= 1'b0;
            data_o      <= '0;
            valid_o     <= 1'b0;
            noise_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (sample_en_i) begin
                prev_q <= smp;
                if (num == slot_a) vs_q[0] <= smp;
                if (num == slot_b) vs_q[1] <= smp;
                unique case (st_q)
                    RX_IDLE: begin
                        if (qual) begin
                            hist_q      <= 3'b000;
                            noise_acc_q <= 1'b0;
                            done_q      <= 1'b0;
                            bit_idx_q   <= '0;
                        end else begin
                            hist_q <= {hist_q[1:0], smp};
                        end
                    end
                    RX_START: begin
                        if (num == slot_c && !maj) noise_acc_q <= split;
                    end
                    RX_DATA: begin
                        if (adv) begin
                            done_q    <= 1'b0;
                            bit_idx_q <= bit_idx_q + 1'b1;
                        end else if (num == slot_c) begin
                            sr_q        <= {maj, sr_q[DATA_BITS-1:1]};
                            noise_acc_q <= noise_acc_q | split;
                            done_q      <= 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (num == slot_c) begin
                            data_o      <= sr_q;
                            valid_o     <= 1'b1;
                            noise_o     <= noise_acc_q | split;
                            frame_err_o <= !maj;
                        end
                    end
                endcase
            end
        end
    end

    // R2: START is entered only from a low sample after three highs, numbered 1 (R3)
    a_r2_qual_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_START && $past(st_q) == RX_IDLE)
        |-> ($past(hist_q) == 3'b111 && !$past(smp) && cnt == CW'(1)));

    // R4: every return to IDLE starts with an empty high-sample history
    a_r4_fresh_history: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_IDLE && $past(st_q) != RX_IDLE) |-> (hist_q == 3'b000));

    // R6: STOP follows only the last data bit
    a_r6_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_STOP && $past(st_q) == RX_DATA) |-> ($past(bit_idx_q) == LAST_BIT));

    // R9: the frame strobe lasts one clock
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: delivered values move only with the strobe
    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data_o) && $stable(noise_o) && $stable(frame_err_o)));
endmodule

// File: tb/osrx_frontend_tb_top.sv
module osrx_frontend_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en;
    logic       resync_en = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] data_o;
    logic       valid_o, noise_o, frame_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    int tdiv   = 0;
    int cyc    = 0;
    bit finished = 1'b0;
    bit cmp_on   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    osrx_frontend dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_i (sample_en),
        .resync_en_i (resync_en),
        .rx_i        (rx),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .noise_o     (noise_o),
        .frame_err_o (frame_err_o)
    );

    // Sample enable: one pulse every four clocks
    always @(posedge clk) tdiv <= (tdiv + 1) % 4;
    assign sample_en = (tdiv == 3);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_s1, m_s2, m_prev, m_mode, m_slot, m_highs, m_voted, m_noise;
    int m_byte;
    int m_samp[17];
    int e_valid, e_byte, e_noise, e_ferr;

    task automatic model_step(input int x);
        int lows, ones;
        if (m_mode == 0) begin
            if (m_highs >= 3 && x == 0) begin
                m_mode = 1; m_slot = 1; m_noise = 0; m_byte = 0; m_voted = 0; m_highs = 0;
            end else begin
                m_highs = x ? ((m_highs < 3) ? m_highs + 1 : 3) : 0;
            end
        end else begin
            if (resync_en && m_mode >= 2 && m_mode <= 9 && x != m_prev) m_slot = 1;
            else m_slot = (m_slot == 16) ? 1 : m_slot + 1;
            m_samp[m_slot] = x;
            if (m_mode == 1) begin
                if (m_slot == 7) begin
                    lows = (m_samp[3] == 0) + (m_samp[5] == 0) + (m_samp[7] == 0);
                    if (lows < 2) begin m_mode = 0; m_highs = 0; end
                    else m_noise = (lows == 2);
                end else if (m_slot == 16) begin
                    m_mode = 2; m_voted = 0;
                end
            end else if (m_mode <= 9) begin
                if (m_slot == 1 && m_voted) begin
                    m_voted = 0; m_mode++;
                end else if (m_slot == 10) begin
                    ones = m_samp[8] + m_samp[9] + m_samp[10];
                    if (ones >= 2) m_byte = m_byte | (1 << (m_mode - 2));
                    if (ones == 1 || ones == 2) m_noise = 1;
                    m_voted = 1;
                end
            end else if (m_slot == 10) begin
                ones = m_samp[8] + m_samp[9] + m_samp[10];
                e_valid = 1;
                e_byte  = m_byte;
                e_noise = (m_noise != 0 || ones == 1 || ones == 2) ? 1 : 0;
                e_ferr  = (ones < 2) ? 1 : 0;
                m_mode  = 0; m_highs = 0;
            end
        end
        m_prev = x;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_mode = 0; m_slot = 1; m_highs = 0;
            m_voted = 0; m_noise = 0; m_byte = 0;
            e_valid = 0; e_byte = 0; e_noise = 0; e_ferr = 0;
        end else begin
            e_valid = 0;
            if (sample_en) model_step(m_s2);   // R11: sampler sees rx from two clocks back
            m_s2 = m_s1;
            m_s1 = rx;
        end
    end

    // Per-clock comparison, away from the active edge
    logic [9:0] capq[$];
    always @(negedge clk) begin
        if (rst_n && cmp_on && !finished) begin
            chk("R9 valid strobe vs model", valid_o, e_valid);
            chk("R6 data byte vs model", data_o, e_byte);
            chk("R7 noise flag vs model", noise_o, e_noise);
            chk("R8 framing flag vs model", frame_err_o, e_ferr);
            if (valid_o) capq.push_back({data_o, noise_o, frame_err_o});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_bit(input logic v, input int n, input int flip);
        for (int k = 0; k < n; k++) begin
            rx = (k == flip) ? ~v : v;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic idle_line(input int n);
        send_bit(1'b1, n, -1);
    endtask

    task automatic send_frame(input logic [7:0] b, input int tpb, input logic stopv,
                              input int sflip, input int dbit, input int dflip);
        send_bit(1'b0, tpb, sflip);
        for (int i = 0; i < 8; i++) send_bit(b[i], tpb, (i == dbit) ? dflip : -1);
        send_bit(stopv, tpb, -1);
    endtask

    task automatic expect_frame(input string tag, input logic [7:0] b, input logic nz, input logic fe);
        logic [9:0] got;
        chk({tag, " frame count"}, capq.size(), 1);
        if (capq.size() > 0) begin
            got = capq.pop_front();
            chk({tag, " byte"}, got[9:2], b);
            chk({tag, " noise"}, got[1], nz);
            chk({tag, " framing"}, got[0], fe);
        end
        capq.delete();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [9:0] f0;
        rst_n = 1'b0;
        rx = 1'b1;
        repeat (6) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", valid_o, 0);
        chk("R1 data in reset", data_o, 0);
        chk("R1 noise in reset", noise_o, 0);
        chk("R1 framing in reset", frame_err_o, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        while (tdiv != 0) @(negedge clk);
        chk("R1 valid after reset", valid_o, 0);
        idle_line(20);

        // R6 R3: clean frame, LSB first
        send_frame(8'hA5, 16, 1'b1, -1, -1, -1);
        idle_line(8);
        expect_frame("R6 clean A5", 8'hA5, 1'b0, 1'b0);

        // R8: stop bit low
        send_frame(8'h3C, 16, 1'b0, -1, -1, -1);
        idle_line(8);
        expect_frame("R8 low stop", 8'h3C, 1'b0, 1'b1);

        // R5: one high among start vote samples (slot 5)
        send_frame(8'h96, 16, 1'b1, 4, -1, -1);
        idle_line(8);
        expect_frame("R5 start noise", 8'h96, 1'b1, 1'b0);

        // R7: data bit 2 disagrees at slot 9, value still by majority
        send_frame(8'h0F, 16, 1'b1, -1, 2, 8);
        idle_line(8);
        expect_frame("R7 data noise", 8'h0F, 1'b1, 1'b0);

        // R4 R2: short low is rejected; two highs then a long low do not qualify
        send_bit(1'b0, 2, -1);
        send_bit(1'b1, 7, -1);
        send_bit(1'b0, 20, -1);
        idle_line(40);
        chk("R4 R2 no frame from rejected or unqualified start", capq.size(), 0);
        capq.delete();

        // R10: slow transmitter (18 samples per bit) recovered by resync
        resync_en = 1'b1;
        send_frame(8'h55, 18, 1'b1, -1, -1, -1);
        idle_line(10);
        expect_frame("R10 resync slow", 8'h55, 1'b0, 1'b0);

        // R10: edge coincides with natural wrap
        send_frame(8'h55, 16, 1'b1, -1, -1, -1);
        idle_line(8);
        expect_frame("R10 resync nominal", 8'h55, 1'b0, 1'b0);

        // R10: without resync the slow frame drifts
        resync_en = 1'b0;
        send_frame(8'h55, 18, 1'b1, -1, -1, -1);
        idle_line(10);
        chk("R10 drift frame count", capq.size(), 1);
        if (capq.size() > 0) begin
            f0 = capq.pop_front();
            chk("R10 drift byte differs", (f0[9:2] != 8'h55), 1);
        end
        capq.delete();

        // R2 R9: back-to-back frames
        send_frame(8'hC3, 16, 1'b1, -1, -1, -1);
        send_frame(8'h81, 16, 1'b1, -1, -1, -1);
        idle_line(8);
        chk("R9 back-to-back count", capq.size(), 2);
        if (capq.size() == 2) begin
            f0 = capq.pop_front();
            chk("R9 first byte", f0[9:2], 8'hC3);
            f0 = capq.pop_front();
            chk("R9 second byte", f0[9:2], 8'h81);
        end
        capq.delete();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule